// File: doc/BRIEF.md
# Reloading Interval Timer with Interrupt Flags

This block is a pair of 16-bit down counters behind a byte-wide register interface. It also holds an interrupt flag register, an interrupt enable register and a single interrupt output. A count-enable input sets the rate. The system normally pulses it at 4.7 MHz / 6. Each counter moves one step on every clock cycle where the count enable is high.

The first counter is the interval timer. When it steps past zero it reloads from a 16-bit period latch. A latch value of zero stands for a period of 65536. In continuous mode, every pass through zero raises the timer flag. The second counter is a free-running count that wraps modulo 65536 and never interrupts.

Software reaches everything through byte reads and writes. The register index comes from address bits [12:9]. Counter writes splice the new byte into the live count. The enable register is updated with set/clear semantics chosen by bit 7 of the written byte.

Top module: `reload_timer_unit`

## Requirements
- R1: The register index is `bus_addr[12:9]`, and address bits [8:0] are ignored. The map is: 4 timer count low, 5 timer count high, 6 period latch low, 7 period latch high, 8 free counter low, 9 free counter high, 11 mode (bits [7:6]), 13 flags, 14 enables. Any other index reads 0x00, and writes to it change nothing.
- R2: After reset both counters read 0xFFFF, the period latch reads 0x0000 (period 65536), the enables read 0x44, the flags read 0x00 and `irq` is low.
- R3: A write to a counter's low byte loads {current high byte, new low byte}. A write to its high byte loads {new high byte, current low byte}.
- R4: The timer counter decreases by one on each cycle where `cnt_en` is high and is unchanged on cycles where it is low.
- R5: On a count step taken at zero, the timer counter loads latch − 1 (modulo 65536). The count therefore repeats every `latch` steps.
- R6: A latch byte write replaces only that byte of the latch and leaves the running count untouched. The new period applies from the next reload.
- R7: Only with mode bits [7:6] = 01 does a zero pass of the timer set flag bit 6. The flag is set on the same clock edge as the reload. Modes 00, 10 and 11 never set it.
- R8: `irq` is high exactly when (flags & enables & 0x44) is non-zero. It follows the flag and enable registers with no extra cycle.
- R9: An enable write with bit 7 = 1 ORs bits [6:0] into the enables. With bit 7 = 0 it clears those bits. Bit 7 reads back as 0.
- R10: A flag write clears every flag bit written as 1. A read of index 4 clears flag bit 6. A `shift_evt` pulse sets flag bit 2. A set wins over a clear in the same cycle.
- R11: The free counter steps down by one per count enable, wraps from 0x0000 to 0xFFFF, loads bytes as in R3, and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_en | input | 1 | Count enable, one step per high cycle |
| bus_addr | input | 13 | Byte address; bits [12:9] select the register |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, acts on the rising edge |
| bus_rd | input | 1 | Read strobe, drives read side effects |
| bus_rdata | output | 8 | Read data, combinational from the selected register |
| shift_evt | input | 1 | Shift-register event, sets flag bit 2 |
| irq | output | 1 | Interrupt request |

## Verification
`bus_rdata` is combinational, so a read returns its value in the cycle where the index is presented. Writes, count steps, flag sets and flag clears all take effect at the next rising edge, and `irq` follows the flags with no further delay. The bench therefore drives each operation on a falling edge. A monitor compares each queued expectation a quarter period after that edge. A result caused by an operation is checked only in a later operation's cycle, after the rising edge that stores it. Count checks step `cnt_en` an exact number of cycles, so each expected count is known exactly.

// File: rtl/rtu_pkg.sv
package rtu_pkg;
  localparam int DATA_W  = 8;
  localparam int CNT_W   = 2 * DATA_W;
  localparam int IDX_W   = 4;
  localparam int IDX_LSB = 9;
  localparam int ADDR_W  = IDX_LSB + IDX_W;
  localparam int NUM_CNT = 2;
  localparam int FLAG_W  = DATA_W - 1;

  localparam logic [IDX_W-1:0] RI_T1_LO  = 4'd4;
  localparam logic [IDX_W-1:0] RI_T1_HI  = 4'd5;
  localparam logic [IDX_W-1:0] RI_LAT_LO = 4'd6;
  localparam logic [IDX_W-1:0] RI_LAT_HI = 4'd7;
  localparam logic [IDX_W-1:0] RI_T2_LO  = 4'd8;
  localparam logic [IDX_W-1:0] RI_T2_HI  = 4'd9;
  localparam logic [IDX_W-1:0] RI_MODE   = 4'd11;
  localparam logic [IDX_W-1:0] RI_FLAGS  = 4'd13;
  localparam logic [IDX_W-1:0] RI_ENABLE = 4'd14;

  localparam logic [1:0]        MODE_CONT = 2'b01;
  localparam int                T1_BIT    = 6;
  localparam int                SR_BIT    = 2;
  localparam logic [FLAG_W-1:0] IRQ_MASK  = 7'h44;
  localparam logic [FLAG_W-1:0] IER_RST   = 7'h44;
  localparam logic [CNT_W-1:0]  CNT_RST   = 16'hFFFF;
  localparam logic [CNT_W-1:0]  LATCH_RST = 16'h0000;
endpackage

// File: rtl/rtu_rst_sync.sv
module rtu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rtu_counter.sv
module rtu_counter #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_i,
  input  logic           ld_lo_i,
  input  logic           ld_hi_i,
  input  logic [W/2-1:0] byte_i,
  input  logic [W-1:0]   reload_i,
  output logic [W-1:0]   cnt_o,
  output logic           zero_pass_o
);
  localparam int HALF = W / 2;

  logic [W-1:0] cnt_q, cnt_d;
  logic         any_ld;

  always_comb begin
    any_ld      = ld_lo_i | ld_hi_i;
    zero_pass_o = tick_i & ~any_ld & (cnt_q == '0);
    cnt_d       = cnt_q;
    if (ld_lo_i)
      cnt_d = {cnt_q[W-1:HALF], byte_i};
    else if (ld_hi_i)
      cnt_d = {byte_i, cnt_q[HALF-1:0]};
    else if (tick_i)
      cnt_d = (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !ld_lo_i && !ld_hi_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !ld_lo_i && !ld_hi_i) |=> $stable(cnt_q));
  // R5
  count_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !ld_lo_i && !ld_hi_i && cnt_q == '0) |=> cnt_q == $past(reload_i));
  // R3
  load_lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo_i |=> (cnt_q[W-1:HALF] == $past(cnt_q[W-1:HALF])) && (cnt_q[HALF-1:0] == $past(byte_i)));
endmodule

// File: rtl/rtu_irq_ctrl.sv
module rtu_irq_ctrl
  import rtu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              t1_evt_i,
  input  logic              sr_evt_i,
  input  logic              t1_ack_i,
  input  logic              flag_wr_i,
  input  logic              en_wr_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [FLAG_W-1:0] ifr_o,
  output logic [FLAG_W-1:0] ier_o,
  output logic              irq_o
);
  logic [FLAG_W-1:0] ifr_q, ifr_d, ier_q, ier_d, set_v;

  always_comb begin
    set_v = '0;
    set_v[T1_BIT] = t1_evt_i;
    set_v[SR_BIT] = sr_evt_i;

    ifr_d = ifr_q;
    if (flag_wr_i) ifr_d = ifr_d & ~byte_i[FLAG_W-1:0];
    if (t1_ack_i)  ifr_d[T1_BIT] = 1'b0;
    ifr_d = ifr_d | set_v;

    ier_d = ier_q;
    if (en_wr_i) begin
      if (byte_i[DATA_W-1]) ier_d = ier_q | byte_i[FLAG_W-1:0];
      else                  ier_d = ier_q & ~byte_i[FLAG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifr_q <= '0;
      ier_q <= IER_RST;
    end else begin
      ifr_q <= ifr_d;
      ier_q <= ier_d;
    end
  end

  assign ifr_o = ifr_q;
  assign ier_o = ier_q;
  assign irq_o = |(ifr_q & ier_q & IRQ_MASK);

  // R9
  ier_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr_i && byte_i[DATA_W-1]) |=> (ier_q & $past(byte_i[FLAG_W-1:0])) == $past(byte_i[FLAG_W-1:0]));
  // R9
  ier_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr_i && !byte_i[DATA_W-1]) |=> (ier_q & $past(byte_i[FLAG_W-1:0])) == '0);
  // R7
  t1_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !t1_evt_i |=> !$rose(ifr_q[T1_BIT]));
  // R10
  sr_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_evt_i |=> ifr_q[SR_BIT]);
endmodule

// File: rtl/reload_timer_unit.sv
module reload_timer_unit
  import rtu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              shift_evt,
  output logic              irq
);
  logic                rst_s;
  logic [IDX_W-1:0]    idx;
  logic [CNT_W-1:0]    latch_q, latch_d;
  logic [1:0]          mode_q, mode_d;
  logic [NUM_CNT-1:0]  ld_lo, ld_hi, zero_pass;
  logic [CNT_W-1:0]    reload [NUM_CNT];
  logic [CNT_W-1:0]    cnt    [NUM_CNT];
  logic [FLAG_W-1:0]   ifr, ier;
  logic                t1_evt, t1_ack, flag_wr, en_wr;

  rtu_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s));

  assign idx = bus_addr[IDX_LSB +: IDX_W];

  // write decode
  always_comb begin
    ld_lo    = '0;
    ld_hi    = '0;
    ld_lo[0] = bus_wr & (idx == RI_T1_LO);
    ld_hi[0] = bus_wr & (idx == RI_T1_HI);
    ld_lo[1] = bus_wr & (idx == RI_T2_LO);
    ld_hi[1] = bus_wr & (idx == RI_T2_HI);
    flag_wr  = bus_wr & (idx == RI_FLAGS);
    en_wr    = bus_wr & (idx == RI_ENABLE);
    t1_ack   = bus_rd & (idx == RI_T1_LO);
  end

  // latch and mode next state
  always_comb begin
    latch_d = latch_q;
    mode_d  = mode_q;
    if (bus_wr && idx == RI_LAT_LO) latch_d[DATA_W-1:0]     = bus_wdata;
    if (bus_wr && idx == RI_LAT_HI) latch_d[CNT_W-1:DATA_W] = bus_wdata;
    if (bus_wr && idx == RI_MODE)   mode_d = bus_wdata[DATA_W-1:DATA_W-2];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      latch_q <= LATCH_RST;
      mode_q  <= 2'b00;
    end else begin
      latch_q <= latch_d;
      mode_q  <= mode_d;
    end
  end

  generate
    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      if (i == 0) begin : g_latched
        assign reload[i] = latch_q - 1'b1;
      end else begin : g_free
        assign reload[i] = '1;
      end
      rtu_counter #(.W(CNT_W), .RST_VAL(CNT_RST)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_s),
        .tick_i     (cnt_en),
        .ld_lo_i    (ld_lo[i]),
        .ld_hi_i    (ld_hi[i]),
        .byte_i     (bus_wdata),
        .reload_i   (reload[i]),
        .cnt_o      (cnt[i]),
        .zero_pass_o(zero_pass[i])
      );
    end
  endgenerate

  assign t1_evt = zero_pass[0] & (mode_q == MODE_CONT);

  rtu_irq_ctrl u_irq (
    .clk      (clk),
    .rst_n    (rst_s),
    .t1_evt_i (t1_evt),
    .sr_evt_i (shift_evt),
    .t1_ack_i (t1_ack),
    .flag_wr_i(flag_wr),
    .en_wr_i  (en_wr),
    .byte_i   (bus_wdata),
    .ifr_o    (ifr),
    .ier_o    (ier),
    .irq_o    (irq)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (idx)
      RI_T1_LO:  bus_rdata = cnt[0][DATA_W-1:0];
      RI_T1_HI:  bus_rdata = cnt[0][CNT_W-1:DATA_W];
      RI_LAT_LO: bus_rdata = latch_q[DATA_W-1:0];
      RI_LAT_HI: bus_rdata = latch_q[CNT_W-1:DATA_W];
      RI_T2_LO:  bus_rdata = cnt[1][DATA_W-1:0];
      RI_T2_HI:  bus_rdata = cnt[1][CNT_W-1:DATA_W];
      RI_MODE:   bus_rdata = {mode_q, {(DATA_W-2){1'b0}}};
      RI_FLAGS:  bus_rdata = {1'b0, ifr};
      RI_ENABLE: bus_rdata = {1'b0, ier};
      default:   bus_rdata = '0;
    endcase
  end

  // R6
  latch_wr_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_wr && (idx == RI_LAT_LO || idx == RI_LAT_HI) && !cnt_en) |=> $stable(cnt[0]));
  // R11
  free_cnt_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (zero_pass[1] && !zero_pass[0] && !shift_evt) |=> $stable(ifr) || $fell(ifr[T1_BIT]) || ($past(bus_wr) && $past(idx) == RI_FLAGS));
endmodule

// File: tb/reload_timer_unit_test.sv
module reload_timer_unit_test;
  import rtu_pkg::*;

  localparam int PERIOD = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cnt_en = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [DATA_W-1:0] bus_rdata;
  logic              shift_evt = 1'b0;
  logic              irq;

  typedef struct {
    bit         is_irq;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int    total = 0;
  int    bad = 0;
  bit    mon_go = 1'b0;
  bit    finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  reload_timer_unit uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .shift_evt(shift_evt), .irq(irq)
  );

  // monitor: compares a quarter period after each falling edge
  always @(negedge clk) begin
    #(PERIOD/4);
    if (mon_go && q.size() > 0) begin
      item_t it;
      logic [7:0] got;
      it  = q.pop_front();
      got = it.is_irq ? {7'b0, irq} : bus_rdata;
      total++;
      if (got !== it.exp) begin
        bad++;
        $display("FAIL %s: got 0x%02h expected 0x%02h", it.tag, got, it.exp);
      end
    end
  end

  function automatic logic [ADDR_W-1:0] mk_addr(input logic [3:0] idx);
    return {idx, 9'h0A5};
  endfunction

  task automatic wr(input logic [3:0] idx, input logic [7:0] d);
    @(negedge clk);
    bus_addr = mk_addr(idx); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] idx, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = mk_addr(idx); bus_rd = 1'b1;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it); mon_go = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; mon_go = 1'b0;
  endtask

  task automatic irq_chk(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = mk_addr(4'd0);
    it.is_irq = 1'b1; it.exp = {7'b0, e}; it.tag = tag;
    q.push_back(it); mon_go = 1'b1;
    @(negedge clk);
    mon_go = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt_en = 1'b1;
    end
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic shift_pulse(input bit with_flag_clear);
    @(negedge clk);
    shift_evt = 1'b1;
    if (with_flag_clear) begin
      bus_addr = mk_addr(RI_FLAGS); bus_wdata = 8'h04; bus_wr = 1'b1;
    end
    @(negedge clk);
    shift_evt = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset state
    rd_chk(RI_T1_LO,  8'hFF, "R2 timer lo");
    rd_chk(RI_T1_HI,  8'hFF, "R2 timer hi");
    rd_chk(RI_LAT_LO, 8'h00, "R2 latch lo");
    rd_chk(RI_LAT_HI, 8'h00, "R2 latch hi");
    rd_chk(RI_T2_HI,  8'hFF, "R2 free hi");
    rd_chk(RI_ENABLE, 8'h44, "R2 enables");
    rd_chk(RI_FLAGS,  8'h00, "R2 flags");
    irq_chk(1'b0, "R2 irq");

    // R1 unmapped index
    wr(4'd0, 8'h5A);
    rd_chk(4'd0, 8'h00, "R1 unmapped read");
    rd_chk(RI_LAT_LO, 8'h00, "R1 unmapped write ignored");

    // R3 byte splicing
    wr(RI_T1_HI, 8'h12);
    rd_chk(RI_T1_LO, 8'hFF, "R3 high write keeps low");
    wr(RI_T1_LO, 8'h34);
    rd_chk(RI_T1_HI, 8'h12, "R3 low write keeps high");
    rd_chk(RI_T1_LO, 8'h34, "R3 low byte");

    // R4 count and hold
    ticks(5);
    rd_chk(RI_T1_LO, 8'h2F, "R4 five steps");
    repeat (3) @(negedge clk);
    rd_chk(RI_T1_LO, 8'h2F, "R4 hold without enable");

    // R6 latch writes leave the count
    wr(RI_LAT_LO, 8'h05);
    wr(RI_LAT_HI, 8'h00);
    rd_chk(RI_T1_LO, 8'h2F, "R6 count untouched");
    rd_chk(RI_LAT_LO, 8'h05, "R6 latch lo");

    // R5 R7 continuous reload
    wr(RI_T1_HI, 8'h00);
    wr(RI_T1_LO, 8'h02);
    wr(RI_MODE, 8'h40);
    ticks(2);
    rd_chk(RI_FLAGS, 8'h00, "R7 no flag before zero pass");
    ticks(1);
    rd_chk(RI_FLAGS, 8'h40, "R7 flag on zero pass");
    irq_chk(1'b1, "R8 irq from timer flag");
    rd_chk(RI_T1_HI, 8'h00, "R5 reload hi");
    rd_chk(RI_T1_LO, 8'h04, "R5 reload latch-1");
    rd_chk(RI_FLAGS, 8'h00, "R10 low read clears timer flag");
    irq_chk(1'b0, "R8 irq drops");
    ticks(4);
    rd_chk(RI_T1_LO, 8'h00, "R5 back at zero");
    ticks(1);
    rd_chk(RI_T1_LO, 8'h04, "R5 period of latch");
    rd_chk(RI_FLAGS, 8'h00, "R10 flag cleared by read");

    // R7 other modes
    wr(RI_MODE, 8'h00);
    ticks(5);
    rd_chk(RI_FLAGS, 8'h00, "R7 mode 00 no flag");
    rd_chk(RI_T1_LO, 8'h04, "R5 reload in mode 00");
    wr(RI_MODE, 8'hC0);
    ticks(5);
    rd_chk(RI_FLAGS, 8'h00, "R7 mode 11 no flag");

    // R9 enable set/clear
    wr(RI_ENABLE, 8'h04);
    rd_chk(RI_ENABLE, 8'h40, "R9 clear bit2");
    wr(RI_ENABLE, 8'h84);
    rd_chk(RI_ENABLE, 8'h44, "R9 set bit2");
    wr(RI_ENABLE, 8'h40);
    rd_chk(RI_ENABLE, 8'h04, "R9 clear bit6");

    // R10 R8 shift flag
    shift_pulse(1'b0);
    rd_chk(RI_FLAGS, 8'h04, "R10 shift sets bit2");
    irq_chk(1'b1, "R8 irq from shift flag");
    wr(RI_FLAGS, 8'h04);
    rd_chk(RI_FLAGS, 8'h00, "R10 write one clears");
    irq_chk(1'b0, "R8 irq after clear");
    wr(RI_ENABLE, 8'h04);
    shift_pulse(1'b0);
    irq_chk(1'b0, "R8 masked flag");
    wr(RI_ENABLE, 8'h84);
    irq_chk(1'b1, "R8 unmask raises irq");
    wr(RI_FLAGS, 8'h04);
    shift_pulse(1'b1);
    rd_chk(RI_FLAGS, 8'h04, "R10 set wins over clear");

    // R11 free counter wrap
    wr(RI_T2_HI, 8'h00);
    wr(RI_T2_LO, 8'h01);
    rd_chk(RI_T2_LO, 8'h01, "R11 load");
    ticks(2);
    rd_chk(RI_T2_LO, 8'hFF, "R11 wrap lo");
    rd_chk(RI_T2_HI, 8'hFF, "R11 wrap hi");
    rd_chk(RI_FLAGS, 8'h04, "R11 no flag");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule